// File: doc/BRIEF.md
# 100 Mb/s Transmit Symbol Coder

This block is the coding half of a fast Ethernet transmit path. It accepts media-independent nibbles at one-fifth of its bit clock and, for each nibble slot, chooses one 5-bit code group. While no frame is active it sends idle. When transmit enable rises it sends a start-of-stream delimiter pair in place of the first two preamble nibbles. It then maps each data nibble to its code group and closes the frame with an end-of-stream pair once transmit enable falls. The code groups are serialised one bit per clock, whitened by an 11-bit scrambler, and converted to NRZI for a line driver further along the path.

The block runs on the bit clock. It raises `nib_take` for one cycle in every five to mark the edge at which the MAC-side inputs are taken. The scrambler seed comes from the port's management address, so neighbouring ports spread their emissions differently. Two static controls bypass the code-group mapping and the scrambler independently.

Top module: `fxc_tx_coder`

## Requirements
- R1: While `rst_n` (synchronous, active low) is low, `tx_bit` and `nib_take` are 0. Bit counting restarts at release, and the first code group sent after release is idle.
- R2: `nib_take` is high during exactly one cycle in five, before edges 5, 10, 15 and so on after release. `txen`, `txd` and `enc_byp` are read only at those edges, and their values at other edges have no effect.
- R3: Outside a frame, the code group sent is idle, 11111.
- R4: The first slot with `txen` high after idle sends J (11000) and the following slot sends K (10001), whatever the nibble values.
- R5: Data nibbles 0..F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: The first slot after data with `txen` low sends T (01101). The next slot sends R (00111) and ignores its inputs. The slot after that is idle, or J if `txen` is high.
- R7: Code groups are written with the first bit on the left and are sent in that order. A group taken at a `nib_take` edge goes out on the five edges that follow.
- R8: Scrambler state s[10:0] steps on every clock with key k = s[10]^s[9-1], s <= {s[9:0],k}. The key is XORed onto each bit. The state is loaded with {addr, ~addr, 1} from `phy_addr` only while reset is held, so later changes of `phy_addr` have no effect.
- R9: `tx_bit` toggles on an edge whose scrambled bit is 1 and holds on an edge whose scrambled bit is 0.
- R10: With `enc_byp` high, the group sent is {txen, txd[3:0]} and no delimiters are added. The framing returns to idle.
- R11: With `scr_byp` high, the key is not applied but the scrambler keeps stepping, so clearing the bypass resumes in phase.
- R12: A frame whose `txen` is high for a single slot still sends J, K, T, R in four consecutive slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low; also loads the scrambler seed |
| phy_addr | input | 5 | Management address used to form the seed |
| enc_byp | input | 1 | Bypass code-group mapping and framing |
| scr_byp | input | 1 | Bypass scrambling |
| txen | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit nibble from the MAC |
| nib_take | output | 1 | High in the cycle whose closing edge takes the inputs |
| tx_bit | output | 1 | NRZI serial output |

## Verification
A nibble presented while `nib_take` is high is taken at that edge. Its code group then appears on the line over the next five edges, one bit per edge, and the scrambler and NRZI stages add no further delay. The bench drives each slot at the falling edge in which `nib_take` is seen and records the expected group under that slot's number. Counting from release, the line bit of edge n is read at the following falling edge. The bench undoes NRZI and the scrambler with its own model, and compares each completed five-bit group against the entry for slot n/5-1. Any slot with no entry is taken to be idle. The strobe is checked on every cycle against the position of its edge within the group of five.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  localparam int NIB_W    = 4;
  localparam int SYM_W    = 5;
  localparam int ADDR_W   = 5;
  localparam int LFSR_W   = 2 * ADDR_W + 1;
  localparam int LFSR_TAP = 9;

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_I = 5'b11111;
  localparam sym_t SYM_J = 5'b11000;
  localparam sym_t SYM_K = 5'b10001;
  localparam sym_t SYM_T = 5'b01101;
  localparam sym_t SYM_R = 5'b00111;

  typedef enum logic [1:0] {ST_IDLE, ST_K, ST_DATA, ST_R} frm_st_e;

  // nibble to data code group
  function automatic sym_t enc_nib(input logic [NIB_W-1:0] n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // address-dependent scrambler seed, never zero
  function automatic logic [LFSR_W-1:0] seed_of(input logic [ADDR_W-1:0] a);
    return {a, ~a, 1'b1};
  endfunction
endpackage

// File: rtl/fxc_framer.sv
module fxc_framer
  import fxc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             txen,
  input  logic [NIB_W-1:0] txd,
  input  logic             enc_byp,
  output sym_t             grp_next,
  output frm_st_e          state
);
  frm_st_e st_nx;

  always_comb begin
    grp_next = SYM_I;
    st_nx    = ST_IDLE;
    if (enc_byp) begin
      grp_next = {txen, txd};
      st_nx    = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          grp_next = txen ? SYM_J : SYM_I;
          st_nx    = txen ? ST_K : ST_IDLE;
        end
        ST_K: begin
          grp_next = SYM_K;
          st_nx    = ST_DATA;
        end
        ST_DATA: begin
          grp_next = txen ? enc_nib(txd) : SYM_T;
          st_nx    = txen ? ST_DATA : ST_R;
        end
        default: begin
          grp_next = SYM_R;
          st_nx    = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= ST_IDLE;
    else if (take) state <= st_nx;
  end
endmodule

// File: rtl/fxc_serializer.sv
module fxc_serializer #(
  parameter int               SYM_W   = 5,
  parameter logic [SYM_W-1:0] RST_SYM = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] grp_in,
  output logic             take,
  output logic             plain_bit,
  output logic [SYM_W-1:0] grp_q
);
  localparam int             CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] bcnt;
  logic [SYM_W-1:0] sh;

  assign take      = (bcnt == LAST);
  assign plain_bit = sh[SYM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt  <= '0;
      sh    <= RST_SYM;
      grp_q <= RST_SYM;
    end else if (take) begin
      bcnt  <= '0;
      sh    <= grp_in;
      grp_q <= grp_in;
    end else begin
      bcnt  <= bcnt + 1'b1;
      sh    <= {sh[SYM_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/fxc_scrambler.sv
module fxc_scrambler #(
  parameter int W   = 11,
  parameter int TAP = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  input  logic         plain_bit,
  input  logic         bypass,
  output logic         scr_bit,
  output logic [W-1:0] state
);
  logic key;

  assign key     = state[W-1] ^ state[TAP-1];
  assign scr_bit = plain_bit ^ (key & ~bypass);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= seed;
    else        state <= {state[W-2:0], key};
  end
endmodule

// File: rtl/fxc_tx_coder.sv
module fxc_tx_coder
  import fxc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              enc_byp,
  input  logic              scr_byp,
  input  logic              txen,
  input  logic [NIB_W-1:0]  txd,
  output logic              nib_take,
  output logic              tx_bit
);
  sym_t              grp_next;
  sym_t              grp_q;
  frm_st_e           frm_state;
  logic              plain_bit;
  logic              scr_bit;
  logic [LFSR_W-1:0] lfsr_q;
  logic              line_q;

  fxc_framer u_frm (
    .clk(clk), .rst_n(rst_n), .take(nib_take), .txen(txen), .txd(txd),
    .enc_byp(enc_byp), .grp_next(grp_next), .state(frm_state)
  );

  fxc_serializer #(.SYM_W(SYM_W), .RST_SYM(SYM_I)) u_ser (
    .clk(clk), .rst_n(rst_n), .grp_in(grp_next), .take(nib_take),
    .plain_bit(plain_bit), .grp_q(grp_q)
  );

  fxc_scrambler #(.W(LFSR_W), .TAP(LFSR_TAP)) u_scr (
    .clk(clk), .rst_n(rst_n), .seed(seed_of(phy_addr)), .plain_bit(plain_bit),
    .bypass(scr_byp), .scr_bit(scr_bit), .state(lfsr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_q ^ scr_bit;
  end

  assign tx_bit = line_q;
endmodule

// File: rtl/fxc_tx_coder_chk.sv
module fxc_tx_coder_chk
  import fxc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              nib_take,
  input logic              txen,
  input logic              enc_byp,
  input logic              tx_bit,
  input logic              scr_bit,
  input logic [LFSR_W-1:0] lfsr_q,
  input frm_st_e           frm_state,
  input sym_t              grp_q
);
  AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    nib_take |=> !nib_take); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_take && !enc_byp && frm_state == ST_IDLE && !txen) |=> (grp_q == SYM_I)); // R3
  AST_J_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_take && !enc_byp && frm_state == ST_IDLE && txen) |=> (grp_q == SYM_J)); // R4
  AST_T_BEFORE_R: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_state == ST_R) |-> (grp_q == SYM_T)); // R6
  AST_R_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_take && !enc_byp && frm_state == ST_R) |=> (grp_q == SYM_R && frm_state == ST_IDLE)); // R6
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R8
  AST_NRZI_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    scr_bit |=> (tx_bit != $past(tx_bit))); // R9
  AST_NRZI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_bit |=> $stable(tx_bit)); // R9
endmodule

bind fxc_tx_coder fxc_tx_coder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nib_take(nib_take), .txen(txen), .enc_byp(enc_byp),
  .tx_bit(tx_bit), .scr_bit(scr_bit), .lfsr_q(lfsr_q), .frm_state(frm_state),
  .grp_q(grp_q)
);

// File: tb/sim_fxc_tx_coder.sv
`timescale 1ns/1ps
module sim_fxc_tx_coder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] phy_addr = 5'h0;
  logic       enc_byp = 1'b0;
  logic       scr_byp = 1'b0;
  logic       txen = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       nib_take;
  logic       tx_bit;

  always #10 clk = ~clk;

  fxc_tx_coder u0 (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .enc_byp(enc_byp),
    .scr_byp(scr_byp), .txen(txen), .txd(txd), .nib_take(nib_take), .tx_bit(tx_bit)
  );

  localparam logic [4:0] C_I = 5'b11111, C_J = 5'b11000, C_K = 5'b10001,
                         C_T = 5'b01101, C_R = 5'b00111;
  localparam logic [4:0] DTAB [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                       5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                       5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                       5'b11010, 5'b11011, 5'b11100, 5'b11101};

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected groups per slot
  logic [4:0] exp_code [int];
  string      exp_tag  [int];
  int         slot_cnt = 0;
  logic       run_q = 1'b0;
  logic       scr_q = 1'b0;

  always @(posedge clk) begin
    run_q <= rst_n;
    scr_q <= scr_byp;
  end

  always @(negedge clk) begin
    if (!run_q) slot_cnt <= 0;
    else if (nib_take) slot_cnt <= slot_cnt + 1;
  end

  // line monitor: undo NRZI and scrambling, regroup
  logic [10:0] m_lfsr;
  logic        m_prev;
  logic [4:0]  m_acc;
  int          m_bits;
  always @(negedge clk) begin
    if (!run_q) begin
      m_lfsr = {phy_addr, ~phy_addr, 1'b1};
      m_prev = 1'b0;
      m_acc  = 5'b0;
      m_bits = 0;
    end else begin
      logic raw, k, pl;
      int g;
      logic [4:0] ec;
      string et;
      raw    = tx_bit ^ m_prev;
      m_prev = tx_bit;
      k      = m_lfsr[10] ^ m_lfsr[8];
      m_lfsr = {m_lfsr[9:0], k};
      pl     = raw ^ (k & ~scr_q);
      m_acc  = {m_acc[3:0], pl};
      m_bits++;
      chk(nib_take == ((m_bits % 5) == 4), "R2 strobe", {4'b0, nib_take}, {4'b0, (m_bits % 5) == 4});
      if (m_bits % 5 == 0) begin
        g  = m_bits / 5 - 1;
        ec = exp_code.exists(g) ? exp_code[g] : C_I;
        et = exp_tag.exists(g) ? exp_tag[g] : (g == 0 ? "R1" : "R3");
        chk(m_acc == ec, et, m_acc, ec);
      end
    end
  end

  task automatic slot(input logic en, input logic [3:0] d, input logic eb,
                      input logic [4:0] code, input string tag, input bit noise);
    int s;
    do @(negedge clk); while (!nib_take);
    s = slot_cnt + 1;
    txen = en; txd = d; enc_byp = eb;
    exp_code[s] = code;
    exp_tag[s]  = tag;
    if (noise) begin
      @(negedge clk);
      txen = ~en; txd = ~d; enc_byp = ~eb;  // R2: off-strobe changes
    end
  endtask

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) slot(1'b0, 4'h0, 1'b0, C_I, "R3", 1'b0);
  endtask

  task automatic do_reset(input logic [4:0] a);
    @(negedge clk);
    rst_n = 1'b0; phy_addr = a;
    txen = 1'b0; txd = 4'h0; enc_byp = 1'b0; scr_byp = 1'b0;
    exp_code.delete(); exp_tag.delete();
    repeat (3) @(negedge clk);
    chk(tx_bit == 1'b0, "R1 line", {4'b0, tx_bit}, 5'b0);
    chk(nib_take == 1'b0, "R1 strobe", {4'b0, nib_take}, 5'b0);
    rst_n = 1'b1;
  endtask

  task automatic frame(input int n, input int base, input bit noise, input string dtag);
    for (int i = 0; i < n; i++) begin
      logic [3:0] nb;
      nb = 4'((base + i) & 15);
      if (i == 0)      slot(1'b1, nb, 1'b0, C_J, "R4", noise);
      else if (i == 1) slot(1'b1, nb, 1'b0, C_K, "R4", noise);
      else             slot(1'b1, nb, 1'b0, DTAB[nb], dtag, noise);
    end
    if (n == 1) slot(1'b0, 4'h0, 1'b0, C_K, "R12", 1'b0);
    slot(1'b0, 4'h0, 1'b0, C_T, "R6", 1'b0);
    slot(1'b0, 4'h0, 1'b0, C_R, "R6", 1'b0);
  endtask

  task automatic test_back_to_back();
    slot(1'b1, 4'h5, 1'b0, C_J, "R4", 1'b0);
    slot(1'b1, 4'h5, 1'b0, C_K, "R4", 1'b0);
    slot(1'b1, 4'h9, 1'b0, DTAB[9], "R5 R7", 1'b0);
    slot(1'b0, 4'h0, 1'b0, C_T, "R6", 1'b0);
    slot(1'b1, 4'h3, 1'b0, C_R, "R6 ignored", 1'b0);
    slot(1'b1, 4'h3, 1'b0, C_J, "R6 restart", 1'b0);
    slot(1'b1, 4'h3, 1'b0, C_K, "R4", 1'b0);
    slot(1'b1, 4'hC, 1'b0, DTAB[12], "R5 R7", 1'b0);
    slot(1'b0, 4'h0, 1'b0, C_T, "R6", 1'b0);
    slot(1'b0, 4'h0, 1'b0, C_R, "R6", 1'b0);
  endtask

  task automatic test_enc_bypass();
    slot(1'b1, 4'hA, 1'b1, 5'b11010, "R10", 1'b0);
    slot(1'b0, 4'h5, 1'b1, 5'b00101, "R10", 1'b0);
    slot(1'b1, 4'h0, 1'b1, 5'b10000, "R10", 1'b0);
    slot(1'b0, 4'h0, 1'b0, C_I, "R10 idle", 1'b0);
  endtask

  task automatic test_nrzi();
    logic p;
    @(negedge clk);
    scr_byp = 1'b1;
    repeat (12) @(negedge clk);
    p = tx_bit;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(tx_bit != p, "R9 toggle", {4'b0, tx_bit}, {4'b0, ~p});
      p = tx_bit;
    end
  endtask

  initial begin
    do_reset(5'h02);
    idle_slots(3);
    frame(18, 0, 1'b1, "R5 R7");
    idle_slots(2);
    frame(1, 4, 1'b0, "R12");
    idle_slots(1);
    test_back_to_back();
    idle_slots(2);
    test_enc_bypass();
    idle_slots(2);
    test_nrzi();
    frame(6, 11, 1'b0, "R11");
    idle_slots(1);
    @(negedge clk);
    scr_byp = 1'b0;
    idle_slots(2);
    @(negedge clk);
    phy_addr = 5'h15;
    frame(5, 3, 1'b0, "R8 addr");
    idle_slots(2);
    do_reset(5'h1D);
    idle_slots(2);
    frame(6, 7, 1'b0, "R8 seed");
    idle_slots(3);
    repeat (12) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule